// File: doc/BRIEF.md
# External Bus Width Adapter

This block connects an internal bus master to a 16-bit external data bus. The master issues one request at a time for a byte, a word or a longword at a given address. The top address bits pick one of several address areas. A per-area configuration bit says whether that area has an 8-bit or a 16-bit data path. The block splits the request into one, two or four external bus cycles. It places write bytes on the correct data lanes, steps the external address between cycles, and builds the read result from the returned bytes.

An 8-bit area uses only the upper lane. A 16-bit area uses both lanes, and a byte goes on the lane that matches the parity of its address. Data is big-endian: the most significant byte sits at the lowest address. Each external cycle waits for a ready input. When the last cycle ends, the block pulses a completion flag together with the assembled read data. Misaligned requests are refused without touching the bus.

Top module: `xbus_sizer`

## Requirements
- R1: `req_size` encodes 0 as byte, 1 as word and 2 as longword. Code 3 is reserved and is rejected in the same way as a misaligned request (R9).
- R2: The top `AREA_BITS` bits of `req_addr` select a bit of `area_wide`. A 1 marks a 16-bit area and a 0 marks an 8-bit area.
- R3: In an 8-bit area, every external cycle moves one byte, on `ext_data_o[15:8]` / `ext_data_i[15:8]`. Only `ext_hi_en` is asserted. A byte takes 1 cycle, a word 2 and a longword 4. `ext_addr` rises by 1 after each cycle.
- R4: In a 16-bit area, a byte takes one cycle. An even address uses the upper lane `[15:8]` with only `ext_hi_en`. An odd address uses the lower lane `[7:0]` with only `ext_lo_en`. A word takes one cycle with both strobes asserted.
- R5: In a 16-bit area, a longword takes two word cycles, and `ext_addr` rises by 2 between them.
- R6: The byte order is big-endian. The byte at the request address is the most significant byte of the operand. Read data is returned right-aligned in `rdata` and zero-extended. For writes, the operand is taken from the low bits of `req_wdata`.
- R7: An external cycle lasts until `ext_ready` is sampled high. While it waits, `ext_addr`, `ext_data_o`, the strobes and `ext_we` hold steady.
- R8: `done` goes high for exactly one clock, in the cycle after the edge on which the last `ext_ready` is sampled. `rdata` is valid in that same cycle. `req_ready` is low from acceptance until that point.
- R9: A word at an odd address, a longword at an odd address, or a reserved size raises `err` for one clock in the cycle after acceptance. It starts no external cycle and gives no `done`.
- R10: While reset is high, the following are all low: `ext_cyc`, `ext_we`, both strobes, `done`, `err` and `rdata`. `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when `req_ready` is high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access size code |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write operand, right-aligned |
| area_wide | input | 2**AREA_BITS | Per-area data width, 1 means 16-bit |
| req_ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock rejection pulse |
| rdata | output | 32 | Assembled read data |
| ext_cyc | output | 1 | External cycle in progress |
| ext_we | output | 1 | External cycle is a write |
| ext_addr | output | AW | External byte address |
| ext_hi_en | output | 1 | Upper lane strobe |
| ext_lo_en | output | 1 | Lower lane strobe |
| ext_data_o | output | 16 | Write data lanes |
| ext_data_i | input | 16 | Read data lanes |
| ext_ready | input | 1 | Ends the current external cycle |

## Verification
The bench targets three groups of corner cases.

- Odd-address bytes in a 16-bit area. A design that uses the wrong lane or strobe there would corrupt the neighbouring byte in the bench's memory model.
- Word-aligned but not longword-aligned longwords. A design that demands 4-byte alignment would wrongly reject them.
- Odd words, odd longwords and the reserved size. A design that lets these through would start bus cycles.

The external model puts a marker value on the lower lane of 8-bit areas, so reads that sample the wrong lane show up. It also varies its ready delay, which tests that the address holds while a cycle waits and that the cycle count and the address step are correct for each size and area width. A reset applied in the middle of a longword must leave the bus idle, and the next access must complete normally.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int LANE_W = 16;
  localparam int OPND_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xsize_e;
endpackage

// File: rtl/xbus_area_map.sv
module xbus_area_map #(
  parameter int AREA_BITS = 3,
  localparam int NAREA = 1 << AREA_BITS
) (
  input  logic [AREA_BITS-1:0] area_idx,
  input  logic [NAREA-1:0]     area_wide,
  output logic                 wide
);
  always_comb wide = area_wide[area_idx];
endmodule

// File: rtl/xbus_plan.sv
module xbus_plan
  import xbus_pkg::*;
(
  input  logic [1:0]        size,
  input  logic              a0,
  input  logic              wide,
  input  logic [OPND_W-1:0] wdata,
  output logic              bad,
  output logic [1:0]        ncyc_m1,
  output logic              bmode,
  output logic [OPND_W-1:0] walign
);
  xsize_e sz;
  always_comb begin
    sz    = xsize_e'(size);
    bad   = (sz == SZ_RSVD) || ((sz != SZ_BYTE) && a0);
    bmode = !wide || (sz == SZ_BYTE);
    unique case (sz)
      SZ_BYTE: begin ncyc_m1 = 2'd0;                    walign = {wdata[7:0], 24'h0}; end
      SZ_WORD: begin ncyc_m1 = wide ? 2'd0 : 2'd1;      walign = {wdata[15:0], 16'h0}; end
      SZ_LONG: begin ncyc_m1 = wide ? 2'd1 : 2'd3;      walign = wdata; end
      default: begin ncyc_m1 = 2'd0;                    walign = '0; end
    endcase
  end
endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
  import xbus_pkg::*;
(
  input  logic              wide,
  input  logic              bmode,
  input  logic              a0,
  input  logic [LANE_W-1:0] wtop,
  output logic [LANE_W-1:0] lane_data,
  output logic              hi_en,
  output logic              lo_en
);
  always_comb begin
    if (!wide) begin
      hi_en     = 1'b1;
      lo_en     = 1'b0;
      lane_data = {wtop[15:8], 8'h00};
    end else if (bmode) begin
      hi_en     = !a0;
      lo_en     = a0;
      lane_data = a0 ? {8'h00, wtop[15:8]} : {wtop[15:8], 8'h00};
    end else begin
      hi_en     = 1'b1;
      lo_en     = 1'b1;
      lane_data = wtop;
    end
  end
endmodule

// File: rtl/xbus_merge.sv
module xbus_merge
  import xbus_pkg::*;
(
  input  logic              wide,
  input  logic              bmode,
  input  logic              a0,
  input  logic [OPND_W-1:0] acc,
  input  logic [LANE_W-1:0] lanes_in,
  output logic [OPND_W-1:0] acc_next
);
  always_comb begin
    if (!wide)
      acc_next = {acc[23:0], lanes_in[15:8]};
    else if (bmode)
      acc_next = {acc[23:0], (a0 ? lanes_in[7:0] : lanes_in[15:8])};
    else
      acc_next = {acc[15:0], lanes_in};
  end
endmodule

// File: rtl/xbus_sizer.sv
module xbus_sizer
  import xbus_pkg::*;
#(
  parameter int AW = 24,
  parameter int AREA_BITS = 3,
  localparam int NAREA = 1 << AREA_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [OPND_W-1:0] req_wdata,
  input  logic [NAREA-1:0]  area_wide,
  output logic              req_ready,
  output logic              done,
  output logic              err,
  output logic [OPND_W-1:0] rdata,
  output logic              ext_cyc,
  output logic              ext_we,
  output logic [AW-1:0]     ext_addr,
  output logic              ext_hi_en,
  output logic              ext_lo_en,
  output logic [LANE_W-1:0] ext_data_o,
  input  logic [LANE_W-1:0] ext_data_i,
  input  logic              ext_ready
);
  logic              busy_q, wide_q, bmode_q, we_q, done_q, err_q, hi_q, lo_q;
  logic [1:0]        cnt_q;
  logic [AW-1:0]     addr_q;
  logic [OPND_W-1:0] wsh_q, acc_q, rdata_q;
  logic [LANE_W-1:0] wd_q;

  logic              req_wide, plan_bad, plan_bmode;
  logic [1:0]        plan_ncyc;
  logic [OPND_W-1:0] plan_walign, acc_n, wsh_step;
  logic [AW-1:0]     addr_step;
  logic              accept, sel_wide, sel_bmode, sel_a0, ln_hi, ln_lo;
  logic [OPND_W-1:0] sel_wsh;
  logic [LANE_W-1:0] ln_data;

  xbus_area_map #(.AREA_BITS(AREA_BITS)) u_area (
    .area_idx (req_addr[AW-1 -: AREA_BITS]),
    .area_wide(area_wide),
    .wide     (req_wide)
  );

  xbus_plan u_plan (
    .size   (req_size),
    .a0     (req_addr[0]),
    .wide   (req_wide),
    .wdata  (req_wdata),
    .bad    (plan_bad),
    .ncyc_m1(plan_ncyc),
    .bmode  (plan_bmode),
    .walign (plan_walign)
  );

  always_comb begin
    accept    = req_valid && !busy_q;
    addr_step = addr_q + {{(AW-2){1'b0}}, (bmode_q ? 2'd1 : 2'd2)};
    wsh_step  = bmode_q ? {wsh_q[23:0], 8'h0} : {wsh_q[15:0], 16'h0};
    sel_wide  = accept ? req_wide    : wide_q;
    sel_bmode = accept ? plan_bmode  : bmode_q;
    sel_a0    = accept ? req_addr[0] : addr_step[0];
    sel_wsh   = accept ? plan_walign : wsh_step;
  end

  xbus_lanes u_lanes (
    .wide     (sel_wide),
    .bmode    (sel_bmode),
    .a0       (sel_a0),
    .wtop     (sel_wsh[31:16]),
    .lane_data(ln_data),
    .hi_en    (ln_hi),
    .lo_en    (ln_lo)
  );

  xbus_merge u_merge (
    .wide    (wide_q),
    .bmode   (bmode_q),
    .a0      (addr_q[0]),
    .acc     (acc_q),
    .lanes_in(ext_data_i),
    .acc_next(acc_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; wide_q <= 1'b0; bmode_q <= 1'b0; we_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; hi_q <= 1'b0; lo_q <= 1'b0;
      cnt_q <= '0; addr_q <= '0; wsh_q <= '0; acc_q <= '0;
      rdata_q <= '0; wd_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (accept) begin
          if (plan_bad) begin
            err_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            cnt_q   <= plan_ncyc;
            wide_q  <= req_wide;
            bmode_q <= plan_bmode;
            we_q    <= req_write;
            addr_q  <= req_addr;
            wsh_q   <= plan_walign;
            acc_q   <= '0;
            hi_q    <= ln_hi;
            lo_q    <= ln_lo;
            wd_q    <= ln_data;
          end
        end
      end else if (ext_ready) begin
        acc_q <= acc_n;
        if (cnt_q == 2'd0) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= acc_n;
          we_q    <= 1'b0;
          hi_q    <= 1'b0;
          lo_q    <= 1'b0;
          wd_q    <= '0;
        end else begin
          cnt_q  <= cnt_q - 2'd1;
          addr_q <= addr_step;
          wsh_q  <= wsh_step;
          hi_q   <= ln_hi;
          lo_q   <= ln_lo;
          wd_q   <= ln_data;
        end
      end
    end
  end

  assign req_ready  = !busy_q;
  assign done       = done_q;
  assign err        = err_q;
  assign rdata      = rdata_q;
  assign ext_cyc    = busy_q;
  assign ext_we     = we_q;
  assign ext_addr   = addr_q;
  assign ext_hi_en  = hi_q;
  assign ext_lo_en  = lo_q;
  assign ext_data_o = wd_q;

  a_r7_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
    busy_q && !ext_ready |=> busy_q && $stable(addr_q) && $stable(wd_q) && $stable({hi_q, lo_q, we_q}));
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r8_done_after_ready: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q && ext_ready));
  a_r9_err_no_cycle: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !busy_q && !done_q);
  a_r3_narrow_upper_only: assert property (@(posedge clk) disable iff (rst)
    busy_q && !wide_q |-> hi_q && !lo_q);
  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
    busy_q && wide_q && bmode_q |-> $onehot({hi_q, lo_q}));
endmodule

// File: tb/tb_xbus_sizer.sv
module tb_xbus_sizer;
  localparam int AW = 24;
  localparam int AREA_BITS = 3;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0] area_wide = 8'b0000_0010;
  logic req_ready, done, err, ext_cyc, ext_we, ext_hi_en, ext_lo_en;
  logic [31:0] rdata;
  logic [AW-1:0] ext_addr;
  logic [15:0] ext_data_o;
  logic [15:0] ext_data_i = '0;
  logic ext_ready = 1'b0;

  always #5 clk = ~clk;

  xbus_sizer #(.AW(AW), .AREA_BITS(AREA_BITS)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .area_wide(area_wide), .req_ready(req_ready), .done(done), .err(err),
    .rdata(rdata), .ext_cyc(ext_cyc), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_hi_en(ext_hi_en), .ext_lo_en(ext_lo_en), .ext_data_o(ext_data_o),
    .ext_data_i(ext_data_i), .ext_ready(ext_ready)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] snap [256];
  logic cur_wide = 1'b0, cur_we = 1'b0;
  logic [1:0] cur_size = '0;
  logic [AW-1:0] exp_addr = '0, hold_addr = '0;
  int step = 1, cyc_txn = 0, cyc_total = 0, wait_n = 0;

  // vector: write, size, addr, wdata, expected cycles, expected err
  localparam logic [62:0] VEC [NV] = '{
    {1'b0, 2'd0, 24'h000010, 32'h0,        3'd1, 1'b0}, // R3 byte, 8-bit area
    {1'b0, 2'd1, 24'h000012, 32'h0,        3'd2, 1'b0}, // R3 word
    {1'b0, 2'd2, 24'h000020, 32'h0,        3'd4, 1'b0}, // R3 R6 long
    {1'b0, 2'd0, 24'h200030, 32'h0,        3'd1, 1'b0}, // R4 even byte
    {1'b0, 2'd0, 24'h200031, 32'h0,        3'd1, 1'b0}, // R4 odd byte
    {1'b0, 2'd1, 24'h200032, 32'h0,        3'd1, 1'b0}, // R4 word
    {1'b0, 2'd2, 24'h200040, 32'h0,        3'd2, 1'b0}, // R5 long
    {1'b1, 2'd0, 24'h000050, 32'h000000A5, 3'd1, 1'b0}, // R3 write byte
    {1'b1, 2'd2, 24'h000054, 32'h11223344, 3'd4, 1'b0}, // R6 write long
    {1'b1, 2'd0, 24'h200061, 32'h0000003C, 3'd1, 1'b0}, // R4 odd write
    {1'b1, 2'd0, 24'h200062, 32'h000000C3, 3'd1, 1'b0}, // R4 even write
    {1'b1, 2'd1, 24'h200064, 32'h0000BEEF, 3'd1, 1'b0}, // R4 word write
    {1'b1, 2'd2, 24'h200068, 32'hCAFEF00D, 3'd2, 1'b0}, // R5 long write
    {1'b0, 2'd1, 24'h200033, 32'h0,        3'd0, 1'b1}, // R9 odd word
    {1'b0, 2'd2, 24'h000022, 32'h0,        3'd4, 1'b0}, // R6 word-aligned long
    {1'b1, 2'd2, 24'h200043, 32'h12345678, 3'd0, 1'b1}, // R9 odd long
    {1'b0, 2'd3, 24'h000000, 32'h0,        3'd0, 1'b1}, // R1 reserved size
    {1'b0, 2'd2, 24'h200046, 32'h0,        3'd2, 1'b0}  // R5 long at 2 mod 4
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // external device model
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    forever begin
      @(negedge clk);
      if (rst || !ext_cyc) begin
        ext_ready = 1'b0;
        wait_n = 0;
      end else begin
        if (ext_ready) wait_n = 0;
        if (wait_n == 0) hold_addr = ext_addr;
        else chk(ext_addr == hold_addr, "R7 addr hold", 32'(ext_addr), 32'(hold_addr));
        if (wait_n >= cyc_total % 3) begin
          chk(ext_addr == exp_addr, "R3/R5 address step", 32'(ext_addr), 32'(exp_addr));
          chk(ext_we == cur_we, "R7 direction", 32'(ext_we), 32'(cur_we));
          if (!cur_wide)
            chk(ext_hi_en && !ext_lo_en, "R3 strobes", {ext_hi_en, ext_lo_en}, 2'b10);
          else if (cur_size == 2'd0)
            chk(ext_hi_en == !ext_addr[0] && ext_lo_en == ext_addr[0], "R4 byte strobe",
                {ext_hi_en, ext_lo_en}, {!ext_addr[0], ext_addr[0]});
          else
            chk(ext_hi_en && ext_lo_en, "R4 word strobes", {ext_hi_en, ext_lo_en}, 2'b11);
          if (!cur_wide) begin
            ext_data_i = {mem[ext_addr[7:0]], 8'hEE};
            if (ext_we && ext_hi_en) mem[ext_addr[7:0]] = ext_data_o[15:8];
          end else begin
            ext_data_i = {mem[{ext_addr[7:1], 1'b0}], mem[{ext_addr[7:1], 1'b1}]};
            if (ext_we && ext_hi_en) mem[{ext_addr[7:1], 1'b0}] = ext_data_o[15:8];
            if (ext_we && ext_lo_en) mem[{ext_addr[7:1], 1'b1}] = ext_data_o[7:0];
          end
          exp_addr = exp_addr + AW'(step);
          cyc_txn++;
          cyc_total++;
          ext_ready = 1'b1;
        end else begin
          ext_ready = 1'b0;
          wait_n++;
        end
      end
    end
  end

  task automatic run_txn(input logic we, input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [31:0] wd, input int exp_cyc, input bit exp_err);
    int nb;
    logic [31:0] exp_rd;
    logic [7:0] a8;
    bit got_done, got_err;
    logic [31:0] got_rd;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    a8 = a[7:0];
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    exp_rd = '0;
    for (int k = 0; k < nb; k++) exp_rd = {exp_rd[23:0], snap[8'(a8 + 8'(k))]};
    cur_wide = area_wide[a[AW-1 -: AREA_BITS]];
    cur_we = we; cur_size = sz; exp_addr = a;
    step = cur_wide ? 2 : 1;
    cyc_txn = 0;
    got_done = 1'b0; got_err = 1'b0; got_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_size = sz; req_addr = a; req_wdata = wd;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_valid = 1'b0;
        if (!exp_err) chk(req_ready == 1'b0, "R8 busy", 32'(req_ready), 32'd0);
      end
      if (done || err) begin
        got_done = done; got_err = err; got_rd = rdata;
        break;
      end
    end
    chk(got_err == exp_err, "R9 err", 32'(got_err), 32'(exp_err));
    chk(got_done == !exp_err, "R8 done", 32'(got_done), 32'(!exp_err));
    @(negedge clk);
    chk(!done && !err, "R8 single pulse", {done, err}, 2'b00);
    chk(cyc_txn == exp_cyc, "R3/R4/R5 cycle count", 32'(cyc_txn), 32'(exp_cyc));
    if (!we && !exp_err)
      chk(got_rd == exp_rd, "R6 read data", got_rd, exp_rd);
    if (we || exp_err) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] e;
        e = snap[i];
        if (we && !exp_err)
          for (int k = 0; k < nb; k++)
            if (8'(i) == 8'(a8 + 8'(k))) e = wd[8*(nb-1-k) +: 8];
        if (mem[i] != e) chk(1'b0, "R6 memory image", 32'(mem[i]), 32'(e));
      end
      n_chk++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!ext_cyc && !ext_we && !ext_hi_en && !ext_lo_en, "R10 bus idle",
        {ext_cyc, ext_we, ext_hi_en, ext_lo_en}, 0);
    chk(!done && !err && rdata == 0, "R10 flags", rdata, 0);
    chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    // R2 area table from vectors; R1 size codes inside
    for (int v = 0; v < NV; v++) begin
      logic [62:0] e;
      e = VEC[v];
      run_txn(e[62], e[61:60], e[59:36], e[35:4], int'(e[3:1]), e[0]);
    end
    // R2: flip area 1 to narrow; word read now takes two cycles
    area_wide = 8'b0000_0000;
    run_txn(1'b0, 2'd1, 24'h200032, 32'h0, 2, 1'b0);
    area_wide = 8'b0000_0010;
    // R10 reset in the middle of a longword
    cur_wide = 1'b0; cur_we = 1'b0; cur_size = 2'd2; exp_addr = 24'h000020; step = 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 24'h000020;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!ext_cyc && req_ready && !done, "R10 reset mid access", {ext_cyc, req_ready, done}, 3'b010);
    rst = 1'b0;
    @(negedge clk);
    run_txn(1'b0, 2'd2, 24'h200040, 32'h0, 2, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule